// File: doc/BRIEF.md
# Change-Triggered Interrupt Aggregator with Message Output

This block gathers eleven external interrupt lines into one notification towards a processor. The notification is a single write transaction, presented on an outbound request/acknowledge handshake, whose address and data word both come from one software-programmed target register. Each line passes through a two-flop synchroniser. A change on a synchronised line, rising or falling, is latched as an event.

Software reaches five registers through a simple 32-bit read/write port: the target, an enable mask, a request register that latches changes on enabled lines, a pending register that latches changes on any implemented line, and a live level register. Requests and pending bits clear when they are read. Notifications come only from changes and never from a line that is merely held high. Software can still emulate level-triggered sharing: after servicing the requests, it reads the level register masked with its enables and loops while any enabled line is still asserted.

Top module: `irqagg_top`

## Requirements
- R1: A read at offset 0x28 returns the synchronised current state of all eleven lines in bits 10:0, whether or not they are enabled. A write there has no effect.
- R2: A change in either direction on line i sets request bit i (read at offset 0x0C) only when mask bit i is set and bit i is implemented. The implemented set is 0x5FF, so line 9 never sets a request or pending bit.
- R3: A read of the request register returns its bits and clears them in the same access. A bit set by a change in that same cycle survives the clear.
- R4: The pending register (offset 0x1C) latches changes on every implemented line regardless of the mask. A read returns and clears it, and leaves the level register unchanged.
- R5: The mask is the 11-bit register at offset 0x18. Setting a mask bit while its line is already asserted raises no notification.
- R6: A notification holds msg_req high until msg_ack. For the whole wait it presents msg_addr equal to the target with bits 4:0 cleared, and msg_data equal to the target bits 4:0 zero-extended.
- R7: All enabled changes that occur while no notification is outstanding produce exactly one notification. Any changes arriving while one awaits acknowledge are merged into exactly one further notification, raised after msg_req has been low for one cycle.
- R8: Reset clears the mask, request, pending and target registers. No notification is raised until the target register has been written.
- R9: The target register at offset 0x04 reads back what was written. Reads at any unlisted offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 11 | Asynchronous interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects at the clock edge) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid while reg_rd is high |
| msg_req | output | 1 | Notification write request |
| msg_addr | output | 32 | Notification target address |
| msg_data | output | 32 | Notification data word |
| msg_ack | input | 1 | Notification acknowledge |

## Verification
The handshake assertions assume that msg_ack is raised only while msg_req is high, and for one cycle per transaction. The bench's responder drives acknowledge on exactly that rule, and it can be held off so that changes pile up behind an outstanding notification. The read-clear assertion assumes that reg_rd is a single-cycle strobe. The bench's read task always drives it that way, and never issues a read and a write together. Interrupt lines are changed only at falling edges and then held for several cycles. Every change is therefore seen by the synchroniser as one clean transition.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int LINES     = 11;
    localparam int REG_AW    = 8;
    localparam int WORD_W    = 32;
    localparam int DATA_BITS = 5;

    typedef logic [LINES-1:0] line_vec_t;

    localparam line_vec_t IMPL_LINES = 11'h5FF;

    typedef enum logic [REG_AW-1:0] {
        OFF_TARGET  = 8'h04,
        OFF_REQUEST = 8'h0C,
        OFF_MASK    = 8'h18,
        OFF_PENDING = 8'h1C,
        OFF_LEVEL   = 8'h28
    } reg_off_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } msg_t;

    function automatic msg_t split_target(input logic [WORD_W-1:0] t);
        msg_t m;
        m.addr = {t[WORD_W-1:DATA_BITS], {DATA_BITS{1'b0}}};
        m.data = {{(WORD_W-DATA_BITS){1'b0}}, t[DATA_BITS-1:0]};
        return m;
    endfunction
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] change
);
    for (genvar i = 0; i < W; i++) begin : g_line
        logic meta_q, sync_q, prev_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= async_in[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end
        assign level[i]  = sync_q;
        assign change[i] = sync_q ^ prev_q;
    end
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  line_vec_t         level,
    input  line_vec_t         change,
    output line_vec_t         req_set,
    output line_vec_t         req_bits,
    output logic [WORD_W-1:0] target,
    output logic              tgt_valid
);
    localparam int PAD = WORD_W - LINES;

    line_vec_t mask_q, req_q, pend_q, pend_set;
    logic      rd_req, rd_pend;

    assign req_set  = change & mask_q & IMPL_LINES;
    assign pend_set = change & IMPL_LINES;
    assign rd_req   = reg_rd && (reg_addr == OFF_REQUEST);
    assign rd_pend  = reg_rd && (reg_addr == OFF_PENDING);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '0;
            req_q     <= '0;
            pend_q    <= '0;
            target    <= '0;
            tgt_valid <= 1'b0;
        end else begin
            req_q  <= (rd_req  ? '0 : req_q)  | req_set;
            pend_q <= (rd_pend ? '0 : pend_q) | pend_set;
            if (reg_wr && reg_addr == OFF_MASK)
                mask_q <= reg_wdata[LINES-1:0];
            if (reg_wr && reg_addr == OFF_TARGET) begin
                target    <= reg_wdata;
                tgt_valid <= 1'b1;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                OFF_TARGET:  reg_rdata = target;
                OFF_REQUEST: reg_rdata = {{PAD{1'b0}}, req_q};
                OFF_MASK:    reg_rdata = {{PAD{1'b0}}, mask_q};
                OFF_PENDING: reg_rdata = {{PAD{1'b0}}, pend_q};
                OFF_LEVEL:   reg_rdata = {{PAD{1'b0}}, level};
                default:     reg_rdata = '0;
            endcase
        end
    end

    assign req_bits = req_q;
endmodule

// File: rtl/irqagg_notify.sv
module irqagg_notify
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [WORD_W-1:0] target,
    input  logic              msg_ack,
    output logic              msg_req,
    output logic [WORD_W-1:0] msg_addr,
    output logic [WORD_W-1:0] msg_data
);
    logic req_q, owed_q;
    msg_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            owed_q <= 1'b0;
            held_q <= '0;
        end else if (req_q) begin
            if (msg_ack)
                req_q <= 1'b0;
            owed_q <= owed_q | fire;
        end else if (owed_q || fire) begin
            req_q  <= 1'b1;
            owed_q <= 1'b0;
            held_q <= split_target(target);
        end
    end

    assign msg_req  = req_q;
    assign msg_addr = held_q.addr;
    assign msg_data = held_q.data;
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  irq_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              msg_req,
    output logic [WORD_W-1:0] msg_addr,
    output logic [WORD_W-1:0] msg_data,
    input  logic              msg_ack
);
    line_vec_t         level, change, req_set, req_bits;
    logic [WORD_W-1:0] target;
    logic              tgt_valid, fire;

    irqagg_sync #(.W(LINES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (irq_in),
        .level    (level),
        .change   (change)
    );

    irqagg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .level     (level),
        .change    (change),
        .req_set   (req_set),
        .req_bits  (req_bits),
        .target    (target),
        .tgt_valid (tgt_valid)
    );

    assign fire = (|req_set) && tgt_valid;

    irqagg_notify u_notify (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .target   (target),
        .msg_ack  (msg_ack),
        .msg_req  (msg_req),
        .msg_addr (msg_addr),
        .msg_data (msg_data)
    );
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
    import irqagg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              msg_req,
    input logic              msg_ack,
    input logic [WORD_W-1:0] msg_addr,
    input logic [WORD_W-1:0] msg_data,
    input logic              tgt_valid,
    input logic              reg_rd,
    input logic [REG_AW-1:0] reg_addr,
    input line_vec_t         req_bits,
    input line_vec_t         req_set
);
    assert_hold_req_R6: assert property (@(posedge clk) disable iff (rst)
        (msg_req && !msg_ack) |=> msg_req);

    assert_stable_msg_R6: assert property (@(posedge clk) disable iff (rst)
        (msg_req && !msg_ack) |=> ($stable(msg_addr) && $stable(msg_data)));

    assert_gap_after_ack_R7: assert property (@(posedge clk) disable iff (rst)
        (msg_req && msg_ack) |=> !msg_req);

    assert_no_msg_without_target_R8: assert property (@(posedge clk) disable iff (rst)
        !tgt_valid |-> !msg_req);

    assert_request_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == OFF_REQUEST) |=> ((req_bits & ~$past(req_set)) == '0));
endmodule

bind irqagg_top irqagg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .msg_req   (msg_req),
    .msg_ack   (msg_ack),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .tgt_valid (tgt_valid),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .req_bits  (req_bits),
    .req_set   (req_set)
);

// File: tb/irqagg_top_bench.sv
`timescale 1ns/1ps
module irqagg_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] irq_in = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_req;
    logic [31:0] msg_addr, msg_data;
    logic        msg_ack = 1'b0;

    int total = 0, bad = 0;
    int txn_cnt = 0;
    logic        ack_en = 1'b1;
    logic [31:0] last_addr = '0, last_data = '0;

    always #2.5 clk = ~clk;

    irqagg_top u_irqagg_top (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_req(msg_req), .msg_addr(msg_addr), .msg_data(msg_data),
        .msg_ack(msg_ack)
    );

    typedef struct packed {
        logic [10:0] mask;
        logic [10:0] irq;
        logic [10:0] exp_req;
        logic [10:0] exp_pend;
        logic [10:0] exp_lvl;
        logic [3:0]  exp_txn;
    } row_t;

    localparam row_t ROWS [6] = '{
        '{11'h7FF, 11'h001, 11'h001, 11'h001, 11'h001, 4'd1},
        '{11'h7FF, 11'h000, 11'h001, 11'h001, 11'h000, 4'd1},
        '{11'h7FF, 11'h200, 11'h000, 11'h000, 11'h200, 4'd0},
        '{11'h7FF, 11'h641, 11'h441, 11'h441, 11'h641, 4'd1},
        '{11'h001, 11'h643, 11'h000, 11'h002, 11'h643, 4'd0},
        '{11'h002, 11'h643, 11'h000, 11'h000, 11'h643, 4'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // acknowledge responder
    initial begin
        forever begin
            @(negedge clk);
            if (msg_ack) msg_ack = 1'b0;
            else if (msg_req && ack_en) begin
                msg_ack   = 1'b1;
                txn_cnt++;
                last_addr = msg_addr;
                last_data = msg_data;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int t0;
        settle(3);
        rst = 1'b0;
        settle(2);

        // R8 reset state
        rd(8'h04, v); check("R8 target after reset", v, 32'h0);
        rd(8'h18, v); check("R8 mask after reset", v, 32'h0);
        rd(8'h0C, v); check("R8 request after reset", v, 32'h0);
        rd(8'h1C, v); check("R8 pending after reset", v, 32'h0);
        check("R8 no msg after reset", {31'b0, msg_req}, 32'h0);

        // R8 no notification before target written; R2 still latches
        wr(8'h18, 32'h7FF);
        @(negedge clk); irq_in = 11'h001;
        settle(8);
        check("R8 no txn without target", txn_cnt, 0);
        rd(8'h0C, v); check("R2 request latched without target", v, 32'h001);
        @(negedge clk); irq_in = 11'h000;
        settle(8);
        rd(8'h0C, v);
        rd(8'h1C, v);

        // R9 target readback and unlisted offset
        wr(8'h04, 32'hABCD_0123);
        rd(8'h04, v);  check("R9 target readback", v, 32'hABCD_0123);
        rd(8'h10, v);  check("R9 unlisted offset", v, 32'h0);
        wr(8'h28, 32'h7FF);
        rd(8'h28, v);  check("R1 level write ignored", v, 32'h0);

        // table walk
        foreach (ROWS[i]) begin
            t0 = txn_cnt;
            wr(8'h18, {21'b0, ROWS[i].mask});
            @(negedge clk); irq_in = ROWS[i].irq;
            settle(10);
            check($sformatf("R7 row%0d txn count", i), txn_cnt - t0, {28'b0, ROWS[i].exp_txn});
            rd(8'h0C, v); check($sformatf("R2 row%0d request", i), v, {21'b0, ROWS[i].exp_req});
            rd(8'h0C, v); check($sformatf("R3 row%0d request cleared", i), v, 32'h0);
            rd(8'h1C, v); check($sformatf("R4 row%0d pending", i), v, {21'b0, ROWS[i].exp_pend});
            rd(8'h1C, v); check($sformatf("R4 row%0d pending cleared", i), v, 32'h0);
            rd(8'h28, v); check($sformatf("R1 row%0d level kept", i), v, {21'b0, ROWS[i].exp_lvl});
        end
        rd(8'h18, v); check("R5 mask readback", v, 32'h002);

        // R6 message contents
        check("R6 msg addr", last_addr, 32'hABCD_0120);
        check("R6 msg data", last_data, 32'h0000_0003);

        // R7 merge while waiting for acknowledge
        wr(8'h18, 32'h7FF);
        ack_en = 1'b0;
        t0 = txn_cnt;
        @(negedge clk); irq_in = irq_in ^ 11'h001;
        settle(6);
        check("R6 req held without ack", {31'b0, msg_req}, 32'h1);
        @(negedge clk); irq_in = irq_in ^ 11'h002;
        settle(3);
        @(negedge clk); irq_in = irq_in ^ 11'h004;
        settle(3);
        check("R6 req still held", {31'b0, msg_req}, 32'h1);
        ack_en = 1'b1;
        settle(12);
        check("R7 merged txn count", txn_cnt - t0, 2);
        check("R7 req idle after merge", {31'b0, msg_req}, 32'h0);
        rd(8'h0C, v); check("R3 merged request bits", v, 32'h007);

        // R8 reset clears, target gating again
        @(negedge clk); irq_in = '0;
        settle(8);
        @(negedge clk); rst = 1'b1;
        settle(2);
        rst = 1'b0;
        rd(8'h04, v); check("R8 target cleared", v, 32'h0);
        rd(8'h18, v); check("R8 mask cleared", v, 32'h0);
        t0 = txn_cnt;
        wr(8'h18, 32'h7FF);
        @(negedge clk); irq_in = 11'h400;
        settle(8);
        check("R8 no txn after reset", txn_cnt - t0, 0);
        rd(8'h0C, v); check("R2 line 10 request", v, 32'h400);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule